// File: doc/BRIEF.md
# Scrambled External RAM Port

This block sits between a processor core and a byte-wide external RAM. Every address the core issues passes through a keyed bijective permutation before it reaches the external pins. Every data byte passes through a second keyed permutation whose key is mixed with the plain address of that byte. As a result, the bytes on the bus and in the RAM carry neither the stored values nor the real access order. On a read, the byte returned by the RAM is unscrambled with the same address-mixed key, so the core sees its own data again.

The external bus is never quiet. In every cycle that does not carry a core request, the block issues a read to an address taken from a Galois LFSR. These reads never write, so they leave the RAM unchanged. The secret key sits in a one-time register that can be loaded once after reset. A tamper alarm clears that key at the next clock edge and raises a sticky alarm flag. From then on the core gets a fixed error byte, and the block drives no write strobe on the bus.

Top module: `xmem_guard`

## Requirements
- R1: The address permutation is a bijection on the external address space: no two plain addresses give the same external address under one key, and every external address is used.
- R2: A read from a plain address returns the byte most recently written to that address, across all addresses and all 256 byte values.
- R3: At any fixed address, the data permutation is a bijection: the 256 plain byte values produce 256 distinct bytes on `mem_wdata`.
- R4: The data key is mixed with the plain address, so one byte value written to every address does not produce one single ciphertext on the bus.
- R5: A request is accepted on a rising edge where `cpu_req` is high, no access is in flight and `cpu_rdy` is low. `cpu_rdy` is high for exactly one cycle, two edges after acceptance, and `cpu_rdata` is valid while it is high. A new request cannot be accepted in that cycle.
- R6: From the first edge after reset, `mem_ce` is high in every cycle. In each cycle that is not carrying a request, `mem_we` is low and `mem_addr` holds the next state of an LFSR. That LFSR starts at 1 and steps as next = (s >> 1) XOR (s[0] ? LFSR_TAPS : 0).
- R7: An accepted request takes priority over the dummy access. In the next cycle the bus carries the request: `mem_we` equals the request's write flag, and a plain address maps to the same external address on every access.
- R8: `key_load` takes `key_value` only on its first assertion after reset. Later loads have no effect on the address or data mapping.
- R9: When `tamper_in` is high at an edge, the key register is zero after that edge and `alarm` goes high and stays high until reset. After that, every request returns `ERR_BYTE` (default 8'hE5) and `mem_we` stays low.
- R10: During reset, `mem_ce`, `mem_we`, `cpu_rdy` and `alarm` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core request, held until `cpu_rdy` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Plain byte address |
| cpu_wdata | input | DW | Plain write byte |
| cpu_rdy | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | DW | Plain read byte, or error byte after alarm |
| key_load | input | 1 | One-time key load strobe |
| key_value | input | KW | Key to load |
| tamper_in | input | 1 | Tamper alarm |
| alarm | output | 1 | Sticky alarm flag |
| mem_ce | output | 1 | External chip enable |
| mem_we | output | 1 | External write enable |
| mem_addr | output | AW | Scrambled external address |
| mem_wdata | output | DW | Scrambled write byte |
| mem_rdata | input | DW | Scrambled byte from the RAM |

## Verification
Two functions can meet in one cycle. A core request can arrive in the same cycle in which the LFSR would issue a dummy read, and every request the bench makes does exactly that. The bench checks that the following bus cycle carries the request's write strobe and the same external address for a given plain address each time. It also checks that unbroken idle stretches step through the LFSR sequence, computed in the bench. The second overlap is a tamper pulse against later loads and requests. It is judged by the error byte, the absence of any write strobe, and the flag staying high.

// File: rtl/xg_pkg.sv
package xg_pkg;
   // rotation applied after each mixing round
   function automatic int rot_amount(input int w);
      return (w > 4) ? 3 : 1;
   endfunction

   // rotation of the key half used as round key r
   function automatic int key_shift(input int r, input int kh);
      return (r * 5 + 1) % kh;
   endfunction

   // additive round constant before truncation
   function automatic int round_const(input int r);
      return r * 40503 + 27;
   endfunction
endpackage

// File: rtl/xg_perm_net.sv
module xg_perm_net
   import xg_pkg::*;
#(
   parameter int W       = 8,
   parameter int KH      = 16,
   parameter int ROUNDS  = 4,
   parameter bit INVERSE = 1'b0
) (
   input  logic [W-1:0]  x_in,
   input  logic [KH-1:0] key,
   output logic [W-1:0]  y_out
);
   localparam int ROT = rot_amount(W);

   generate
      if (W < 2 || W > KH) begin : g_bad_width
         $error("xg_perm_net: W must lie in 2..KH");
      end
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("xg_perm_net: at least one round needed");
      end
   endgenerate

   logic [2*KH-1:0] key2;
   logic [W-1:0]    stage [ROUNDS+1];

   assign key2     = {key, key};
   assign stage[0] = x_in;

   // each round: xor round key, add constant, rotate left (all invertible)
   generate
      for (genvar i = 0; i < ROUNDS; i++) begin : g_round
         localparam int RI = INVERSE ? (ROUNDS - 1 - i) : i;
         localparam int SH = key_shift(RI, KH);
         localparam logic [W-1:0] RC = W'(round_const(RI));
         logic [W-1:0] rk;
         assign rk = key2[KH-SH +: W];
         if (!INVERSE) begin : g_fwd
            logic [W-1:0] mixed;
            assign mixed        = (stage[i] ^ rk) + RC;
            assign stage[i+1]   = {mixed[W-1-ROT:0], mixed[W-1:W-ROT]};
         end else begin : g_inv
            logic [W-1:0] unrot;
            assign unrot        = {stage[i][ROT-1:0], stage[i][W-1:ROT]};
            assign stage[i+1]   = (unrot - RC) ^ rk;
         end
      end
   endgenerate

   assign y_out = stage[ROUNDS];
endmodule

// File: rtl/xg_lfsr.sv
module xg_lfsr #(
   parameter int           W    = 15,
   parameter logic [W-1:0] TAPS = 15'h6000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   output logic [W-1:0] state
);
   generate
      if (W < 2) begin : g_bad_w
         $error("xg_lfsr: width below 2");
      end
      if (!TAPS[W-1]) begin : g_bad_taps
         $error("xg_lfsr: top tap must be set");
      end
   endgenerate

   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= W'(1);
      end else if (advance) begin
         q <= (q >> 1) ^ (q[0] ? TAPS : '0);
      end
   end

   assign state = q;

   a_r6_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
   a_r6_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(q));
endmodule

// File: rtl/xg_key_vault.sv
module xg_key_vault #(
   parameter int KW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [KW-1:0] key_in,
   input  logic          tamper,
   output logic [KW-1:0] key_out,
   output logic          alarm_out
);
   logic [KW-1:0] key_q;
   logic          locked_q;
   logic          alarm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q    <= '0;
         locked_q <= 1'b0;
         alarm_q  <= 1'b0;
      end else if (tamper) begin
         key_q    <= '0;
         locked_q <= 1'b1;
         alarm_q  <= 1'b1;
      end else if (load && !locked_q && !alarm_q) begin
         key_q    <= key_in;
         locked_q <= 1'b1;
      end
   end

   assign key_out   = key_q;
   assign alarm_out = alarm_q;

   a_r9_prompt_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      tamper |=> key_q == '0);
   a_r9_key_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q |-> key_q == '0);
   a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q |=> alarm_q);
   a_r8_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> (key_q == $past(key_q)) || (key_q == '0));
endmodule

// File: rtl/xmem_guard.sv
module xmem_guard
   import xg_pkg::*;
#(
   parameter int            AW        = 15,
   parameter int            DW        = 8,
   parameter int            KW        = 32,
   parameter int            ROUNDS    = 4,
   parameter logic [AW-1:0] LFSR_TAPS = 15'h6000,
   parameter logic [DW-1:0] ERR_BYTE  = 8'hE5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_rdy,
   output logic [DW-1:0] cpu_rdata,
   input  logic          key_load,
   input  logic [KW-1:0] key_value,
   input  logic          tamper_in,
   output logic          alarm,
   output logic          mem_ce,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata
);
   localparam int KH = KW / 2;

   generate
      if (KW % 2 != 0) begin : g_bad_kw
         $error("xmem_guard: key width must be even");
      end
      if (AW > KH || DW > KH) begin : g_bad_half
         $error("xmem_guard: key half narrower than a block");
      end
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("xmem_guard: at least one round needed");
      end
   endgenerate

   // key storage and tamper response
   logic [KW-1:0] key_w;
   logic          alarm_w;

   xg_key_vault #(.KW(KW)) u_vault (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (key_load),
      .key_in    (key_value),
      .tamper    (tamper_in),
      .key_out   (key_w),
      .alarm_out (alarm_w)
   );

   logic [KH-1:0] key_addr;
   logic [KH-1:0] key_data;
   assign key_addr = key_w[KH-1:0];
   assign key_data = key_w[KW-1:KH];

   // request tracking
   logic          busy_q;
   logic          rdy_q;
   logic          op_we_q;
   logic [AW-1:0] op_addr_q;
   logic [DW-1:0] rdata_q;
   logic          accept;

   assign accept = cpu_req && !busy_q && !rdy_q;

   // address permutation
   logic [AW-1:0] addr_ct;
   xg_perm_net #(.W(AW), .KH(KH), .ROUNDS(ROUNDS), .INVERSE(1'b0)) u_addr_enc (
      .x_in  (cpu_addr),
      .key   (key_addr),
      .y_out (addr_ct)
   );

   // data permutation, keyed by the plain address of each byte
   logic [KH-1:0] wkey;
   logic [KH-1:0] rkey;
   logic [DW-1:0] wdata_ct;
   logic [DW-1:0] rdata_pt;

   assign wkey = key_data ^ KH'(cpu_addr);
   assign rkey = key_data ^ KH'(op_addr_q);

   xg_perm_net #(.W(DW), .KH(KH), .ROUNDS(ROUNDS), .INVERSE(1'b0)) u_data_enc (
      .x_in  (cpu_wdata),
      .key   (wkey),
      .y_out (wdata_ct)
   );

   xg_perm_net #(.W(DW), .KH(KH), .ROUNDS(ROUNDS), .INVERSE(1'b1)) u_data_dec (
      .x_in  (mem_rdata),
      .key   (rkey),
      .y_out (rdata_pt)
   );

   // dummy address source
   logic [AW-1:0] dummy_addr;
   xg_lfsr #(.W(AW), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (!accept),
      .state   (dummy_addr)
   );

   // external bus and core response
   logic          mem_ce_q;
   logic          mem_we_q;
   logic [AW-1:0] mem_addr_q;
   logic [DW-1:0] mem_wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         rdy_q       <= 1'b0;
         op_we_q     <= 1'b0;
         op_addr_q   <= '0;
         rdata_q     <= '0;
         mem_ce_q    <= 1'b0;
         mem_we_q    <= 1'b0;
         mem_addr_q  <= '0;
         mem_wdata_q <= '0;
      end else begin
         mem_ce_q <= 1'b1;
         busy_q   <= accept;
         rdy_q    <= busy_q;
         if (accept) begin
            op_addr_q <= cpu_addr;
            op_we_q   <= cpu_we;
            if (alarm_w) begin
               mem_addr_q <= dummy_addr;
               mem_we_q   <= 1'b0;
            end else begin
               mem_addr_q  <= addr_ct;
               mem_we_q    <= cpu_we;
               mem_wdata_q <= wdata_ct;
            end
         end else begin
            mem_addr_q <= dummy_addr;
            mem_we_q   <= 1'b0;
         end
         if (busy_q) begin
            if (alarm_w) begin
               rdata_q <= ERR_BYTE;
            end else if (!op_we_q) begin
               rdata_q <= rdata_pt;
            end
         end
      end
   end

   assign cpu_rdy   = rdy_q;
   assign cpu_rdata = rdata_q;
   assign alarm     = alarm_w;
   assign mem_ce    = mem_ce_q;
   assign mem_we    = mem_we_q;
   assign mem_addr  = mem_addr_q;
   assign mem_wdata = mem_wdata_q;

   a_r5_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |=> !cpu_rdy);
   a_r5_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ##2 cpu_rdy);
   a_r6_bus_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce |=> mem_ce);
   a_r6_write_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(accept && cpu_we));
   a_r7_request_first: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !alarm_w |=> mem_we == $past(cpu_we));
   a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      alarm && $past(alarm) |-> !mem_we);
   a_r9_error_byte: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy && $past(alarm) |-> cpu_rdata == ERR_BYTE);
endmodule

// File: tb/xmem_guard_bench.sv
`timescale 1ns/1ps
module xmem_guard_bench;
   localparam int            AW   = 10;
   localparam int            DW   = 8;
   localparam int            KW   = 32;
   localparam int            NA   = 1 << AW;
   localparam logic [AW-1:0] TAPS = 10'h240;
   localparam logic [DW-1:0] ERR  = 8'hE5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_rdy;
   logic [DW-1:0] cpu_rdata;
   logic          key_load = 1'b0;
   logic [KW-1:0] key_value = '0;
   logic          tamper_in = 1'b0;
   logic          alarm;
   logic          mem_ce;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   xmem_guard #(.AW(AW), .DW(DW), .KW(KW), .ROUNDS(4),
                .LFSR_TAPS(TAPS), .ERR_BYTE(ERR)) u_xmem_guard (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy),
      .cpu_rdata(cpu_rdata), .key_load(key_load), .key_value(key_value),
      .tamper_in(tamper_in), .alarm(alarm), .mem_ce(mem_ce), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // external RAM model
   logic [DW-1:0] ram [NA];
   initial for (int i = 0; i < NA; i++) ram[i] = '0;
   always @(posedge clk) if (mem_ce && mem_we) ram[mem_addr] <= mem_wdata;
   assign mem_rdata = ram[mem_addr];

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [AW-1:0] lfsr_next(input logic [AW-1:0] s);
      return (s >> 1) ^ (s[0] ? TAPS : '0);
   endfunction

   task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output logic [AW-1:0] ea,
                        output logic [DW-1:0] ed, output bit ewe);
      @(negedge clk);
      chk(cpu_rdy == 1'b0, "R5 idle before request", cpu_rdy, 0);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      ea = mem_addr; ed = mem_wdata; ewe = mem_we;
      chk(cpu_rdy == 1'b0, "R5 no early ready", cpu_rdy, 0);
      chk(mem_ce == 1'b1, "R6 chip enable", mem_ce, 1);
      @(negedge clk);
      chk(cpu_rdy == 1'b1, "R5 ready after two edges", cpu_rdy, 1);
      rd = cpu_rdata;
      cpu_req = 1'b0;
   endtask

   task automatic idle_chk(input int n);
      logic [AW-1:0] prev;
      @(negedge clk);
      prev = mem_addr;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(mem_ce == 1'b1, "R6 ce high when idle", mem_ce, 1);
         chk(mem_we == 1'b0, "R6 dummy is a read", mem_we, 0);
         chk(mem_addr == lfsr_next(prev), "R6 lfsr sequence", mem_addr, lfsr_next(prev));
         prev = mem_addr;
      end
   endtask

   logic [AW-1:0] ea_w [NA];
   logic [DW-1:0] ed_w [NA];

   initial begin
      logic [DW-1:0] rd, ed;
      logic [AW-1:0] ea;
      bit            ewe;
      bit            seen_a [NA];
      bit            seen_d [256];
      int            dup;
      int            diff;

      // R10 reset state
      repeat (3) @(negedge clk);
      chk(mem_ce == 1'b0, "R10 ce in reset", mem_ce, 0);
      chk(mem_we == 1'b0, "R10 we in reset", mem_we, 0);
      chk(cpu_rdy == 1'b0, "R10 rdy in reset", cpu_rdy, 0);
      chk(alarm == 1'b0, "R10 alarm in reset", alarm, 0);
      rst_n = 1'b1;
      @(negedge clk);
      key_load = 1'b1; key_value = 32'h3C9A_71E5;
      @(negedge clk);
      key_load = 1'b0;

      // R1 bijection, R4 tweak, R7 priority on writes
      for (int a = 0; a < NA; a++) seen_a[a] = 1'b0;
      dup = 0;
      diff = 0;
      for (int a = 0; a < NA; a++) begin
         do_op(1'b1, AW'(a), 8'h5A, rd, ea, ed, ewe);
         ea_w[a] = ea; ed_w[a] = ed;
         chk(ewe == 1'b1, "R7 write reaches bus", ewe, 1);
         if (seen_a[ea]) dup++;
         seen_a[ea] = 1'b1;
         if (ed != ed_w[0]) diff++;
      end
      chk(dup == 0, "R1 no address collision", dup, 0);
      chk(diff > 0, "R4 ciphertext varies with address", diff, 1);

      idle_chk(24);

      // R2 read back, R7 deterministic mapping, reads are reads
      for (int a = 0; a < NA; a++) begin
         do_op(1'b0, AW'(a), 8'h00, rd, ea, ed, ewe);
         chk(rd == 8'h5A, "R2 read back", rd, 8'h5A);
         chk(ea == ea_w[a], "R7 same external address", ea, ea_w[a]);
         chk(ewe == 1'b0, "R7 read has no write", ewe, 0);
      end

      // R3 per-address data bijection, R2 all byte values
      for (int v = 0; v < 256; v++) seen_d[v] = 1'b0;
      dup = 0;
      for (int v = 0; v < 256; v++) begin
         do_op(1'b1, AW'(3), DW'(v), rd, ea, ed, ewe);
         if (seen_d[ed]) dup++;
         seen_d[ed] = 1'b1;
         do_op(1'b0, AW'(3), 8'h00, rd, ea, ed, ewe);
         chk(rd == DW'(v), "R2 byte value round trip", rd, v);
      end
      chk(dup == 0, "R3 data bijection", dup, 0);

      // R8 a second load is ignored
      @(negedge clk);
      key_load = 1'b1; key_value = 32'h0F0F_A5A5;
      @(negedge clk);
      key_load = 1'b0;
      for (int a = 0; a < NA; a++)
         do_op(1'b1, AW'(a), DW'(a ^ (a >> 2)), rd, ea, ed, ewe);
      idle_chk(40);
      for (int a = 0; a < NA; a++) begin
         do_op(1'b0, AW'(a), 8'h00, rd, ea, ed, ewe);
         chk(rd == DW'(a ^ (a >> 2)), "R8 R2 data after reload attempt", rd, DW'(a ^ (a >> 2)));
         chk(ea == ea_w[a], "R8 mapping unchanged", ea, ea_w[a]);
      end

      // R9 tamper
      @(negedge clk);
      tamper_in = 1'b1;
      @(negedge clk);
      tamper_in = 1'b0;
      chk(alarm == 1'b1, "R9 alarm raised", alarm, 1);
      do_op(1'b0, AW'(5), 8'h00, rd, ea, ed, ewe);
      chk(rd == ERR, "R9 error byte on read", rd, ERR);
      do_op(1'b1, AW'(5), 8'h11, rd, ea, ed, ewe);
      chk(ewe == 1'b0, "R9 write blocked", ewe, 0);
      chk(rd == ERR, "R9 error byte on write", rd, ERR);
      @(negedge clk);
      key_load = 1'b1; key_value = 32'h1234_5678;
      @(negedge clk);
      key_load = 1'b0;
      idle_chk(8);
      chk(alarm == 1'b1, "R9 alarm sticky", alarm, 1);
      do_op(1'b0, AW'(5), 8'h00, rd, ea, ed, ewe);
      chk(rd == ERR, "R9 error byte after load attempt", rd, ERR);

      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_up();
   end
endmodule